// File: doc/BRIEF.md
# SCL Divider Register Calculator

This unit turns one requested overall clock divisor into the packed value of a serial-clock timing register: a power-of-two prescaler exponent plus the lengths of the high and low phases of the clock, counted in prescaled ticks. Software or a configuration sequencer places a divisor on `divisor`, pulses `start`, and collects `timing_word` and `clamped` when `done` pulses. The width of the high and low fields is set by the parameter `FIELD_W`, which is 3 or 4.

The work is done over several clock cycles. A control state machine has four states. `ST_IDLE` waits for a start. `ST_SEARCH` raises a trial exponent one step per cycle until the divisor fits, or until the largest exponent has failed. `ST_SHIFT` divides the divisor by two to the exponent, one bit per cycle, rounding up. `ST_DONE` holds for one cycle and raises `done`. The transitions are:
- start accepted: IDLE to SEARCH
- fit found: SEARCH to SHIFT
- exponent advance: SEARCH stays in SEARCH
- overflow clamp: SEARCH to DONE
- shift step: SHIFT stays in SHIFT
- shift drained: SHIFT to DONE
- retire: DONE to IDLE

The result registers load on the transition into DONE.

Top module: `scl_div_calc`

## Requirements
- R1: The largest number of ticks one period can hold is 2^(FIELD_W+1), which is 32 for the default FIELD_W of 4. A divisor no larger than this gives exponent 0.
- R2: A larger divisor gives the smallest exponent e for which divisor <= 2^(FIELD_W+1) * 2^e. This equals floor(log2((divisor-1)/2^(FIELD_W+1))) + 1.
- R3: If no exponent from 0 to 15 fits, the exponent field is 15, both phase fields are all ones, and `clamped` is 1. On every other result `clamped` is 0.
- R4: The tick count per period is the divisor divided by 2^e, rounded up. A tick count below 2 is raised to 2.
- R5: The low phase gets ceil(ticks/2) ticks and the high phase gets floor(ticks/2) ticks. Each field stores its phase length minus one.
- R6: `timing_word` carries the high field in bits 16 upward, the low field in bits 12 upward and the exponent in bits 3:0. All other bits are zero. Example: divisor 33 with FIELD_W=4 gives 32'h0007_8001.
- R7: A divisor of 0 gives the same result as a divisor of 1, which is 32'h0000_0000.
- R8: `done` pulses high for exactly one cycle for each accepted start. `timing_word` and `clamped` hold the new result while `done` is high and keep it until the next `done`.
- R9: A `start` that arrives while a calculation is in progress is ignored. It produces no extra `done`, and the result belongs to the start that was accepted.
- R10: During and right after reset, `done`, `clamped` and `timing_word` are 0.
- R11: `done` arrives no more than 34 cycles after the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation; accepted only when idle |
| divisor | input | DIV_W | Requested overall clock divisor |
| timing_word | output | 32 | Packed exponent, high and low fields |
| clamped | output | 1 | The divisor was too large and every field is at its maximum |
| done | output | 1 | One-cycle pulse: result valid |

## Verification
The bound checker looks at every completion, on every cycle. It checks that `done` never lasts two cycles and never appears without an accepted start. It checks that a clamped result has every field at its maximum, that the low field is equal to the high field or one more, and that no bit outside the three fields is set. It also checks that divisors up to 2^(FIELD_W+1) give exponent zero, that the output changes only when `done` is high, and that completion comes within the latency bound. Only the bench scenarios can show the exact exponent and the rounding at each power-of-two boundary, the handling of divisors 0 and 1, and the dropping of a second start while the unit is busy. The bench compares each result against an independently computed model.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    // Exponent field: width and largest legal value
    localparam int EXP_W    = 4;
    localparam int EXP_LAST = 15;

    // Where the phase fields sit in the packed word
    localparam int HI_LSB   = 16;
    localparam int LO_LSB   = 12;
    localparam int WORD_W   = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_SHIFT,
        ST_DONE
    } calc_state_t;

endpackage

// File: rtl/scl_exp_search.sv
module scl_exp_search
    import scl_div_pkg::*;
#(
    parameter int FIELD_W = 4,
    parameter int DIV_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [DIV_W-1:0] div_in,
    output logic [DIV_W-1:0] norm_div,
    output logic [EXP_W-1:0] exp_val,
    output logic             fits,
    output logic             at_last
);

    localparam int PHASE_MAX = 2 ** (FIELD_W + 1);
    localparam int LIM_W     = DIV_W + EXP_LAST + FIELD_W + 2;

    logic [DIV_W-1:0] d_q;
    logic [EXP_W-1:0] e_q;
    logic [LIM_W-1:0] limit;

    // A zero divisor is normalised to one when it is loaded
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
            e_q <= '0;
        end else if (load) begin
            d_q <= (div_in == '0) ? DIV_W'(1) : div_in;
            e_q <= '0;
        end else if (step) begin
            e_q <= e_q + EXP_W'(1);
        end
    end

    // Largest divisor the current trial exponent can cover
    always_comb begin
        limit   = LIM_W'(PHASE_MAX) << e_q;
        fits    = (LIM_W'(d_q) <= limit);
        at_last = (e_q == EXP_W'(EXP_LAST));
    end

    assign norm_div = d_q;
    assign exp_val  = e_q;

endmodule

// File: rtl/scl_ceil_shift.sv
module scl_ceil_shift
    import scl_div_pkg::*;
#(
    parameter int DIV_W  = 32,
    parameter int TICK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [DIV_W-1:0]  val_in,
    input  logic [EXP_W-1:0]  cnt_in,
    output logic              drained,
    output logic [TICK_W-1:0] tick
);

    logic [DIV_W-1:0] v_q;
    logic [EXP_W-1:0] c_q;
    logic             sticky_q;

    // One bit right per cycle; any one that falls off forces round-up
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q      <= '0;
            c_q      <= '0;
            sticky_q <= 1'b0;
        end else if (load) begin
            v_q      <= val_in;
            c_q      <= cnt_in;
            sticky_q <= 1'b0;
        end else if (step && (c_q != '0)) begin
            v_q      <= v_q >> 1;
            sticky_q <= sticky_q | v_q[0];
            c_q      <= c_q - EXP_W'(1);
        end
    end

    assign drained = (c_q == '0);
    assign tick    = v_q[TICK_W-1:0] + TICK_W'(sticky_q);

endmodule

// File: rtl/scl_phase_pack.sv
module scl_phase_pack
    import scl_div_pkg::*;
#(
    parameter int FIELD_W = 4,
    parameter int TICK_W  = 6
) (
    input  logic [TICK_W-1:0] tick,
    input  logic [EXP_W-1:0]  exp_val,
    input  logic              clamp,
    output logic [WORD_W-1:0] word
);

    logic [TICK_W-1:0]  t_eff;
    logic [TICK_W-1:0]  lo_cnt;
    logic [TICK_W-1:0]  hi_cnt;
    logic [FIELD_W-1:0] lo_f;
    logic [FIELD_W-1:0] hi_f;

    always_comb begin
        // Each phase needs at least one tick
        t_eff  = (tick < TICK_W'(2)) ? TICK_W'(2) : tick;
        // Odd counts give the extra tick to the low phase
        lo_cnt = (t_eff + TICK_W'(1)) >> 1;
        hi_cnt = t_eff >> 1;
        lo_f   = FIELD_W'(lo_cnt) - FIELD_W'(1);
        hi_f   = FIELD_W'(hi_cnt) - FIELD_W'(1);
    end

    // The chosen FIELD_W decides the clamp pattern and how many bits each field occupies
    generate
        if (FIELD_W >= 1 && FIELD_W <= 4) begin : g_pack
            always_comb begin
                word                     = '0;
                word[HI_LSB +: FIELD_W]  = clamp ? {FIELD_W{1'b1}} : hi_f;
                word[LO_LSB +: FIELD_W]  = clamp ? {FIELD_W{1'b1}} : lo_f;
                word[EXP_W-1:0]          = clamp ? EXP_W'(EXP_LAST) : exp_val;
            end
        end else begin : g_bad_width
            assign word = '0;
        end
    endgenerate

endmodule

// File: rtl/scl_div_calc.sv
module scl_div_calc
    import scl_div_pkg::*;
#(
    parameter int FIELD_W = 4,
    parameter int DIV_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  divisor,
    output logic [WORD_W-1:0] timing_word,
    output logic              clamped,
    output logic              done
);

    localparam int TICK_W = FIELD_W + 2;

    calc_state_t state_q, state_d;

    logic              srch_load, srch_step;
    logic              shf_load, shf_step;
    logic              fin_ok, fin_clamp;
    logic [DIV_W-1:0]  norm_div;
    logic [EXP_W-1:0]  exp_val;
    logic              fits, at_last, drained;
    logic [TICK_W-1:0] tick;
    logic [WORD_W-1:0] packed_word;
    logic [WORD_W-1:0] word_q;
    logic              clamp_q;

    scl_exp_search #(
        .FIELD_W (FIELD_W),
        .DIV_W   (DIV_W)
    ) u_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (srch_load),
        .step     (srch_step),
        .div_in   (divisor),
        .norm_div (norm_div),
        .exp_val  (exp_val),
        .fits     (fits),
        .at_last  (at_last)
    );

    scl_ceil_shift #(
        .DIV_W  (DIV_W),
        .TICK_W (TICK_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (shf_load),
        .step    (shf_step),
        .val_in  (norm_div),
        .cnt_in  (exp_val),
        .drained (drained),
        .tick    (tick)
    );

    scl_phase_pack #(
        .FIELD_W (FIELD_W),
        .TICK_W  (TICK_W)
    ) u_pack (
        .tick    (tick),
        .exp_val (exp_val),
        .clamp   (fin_clamp),
        .word    (packed_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and datapath control
    always_comb begin
        state_d   = state_q;
        srch_load = 1'b0;
        srch_step = 1'b0;
        shf_load  = 1'b0;
        shf_step  = 1'b0;
        fin_ok    = 1'b0;
        fin_clamp = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    srch_load = 1'b1;
                    state_d   = ST_SEARCH;
                end
            end
            ST_SEARCH: begin
                if (fits) begin
                    shf_load = 1'b1;
                    state_d  = ST_SHIFT;
                end else if (at_last) begin
                    fin_clamp = 1'b1;
                    state_d   = ST_DONE;
                end else begin
                    srch_step = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (drained) begin
                    fin_ok  = 1'b1;
                    state_d = ST_DONE;
                end else begin
                    shf_step = 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Result registers load on entry to DONE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            clamp_q <= 1'b0;
        end else if (fin_ok || fin_clamp) begin
            word_q  <= packed_word;
            clamp_q <= fin_clamp;
        end
    end

    // Outputs
    always_comb begin
        done        = (state_q == ST_DONE);
        timing_word = word_q;
        clamped     = clamp_q;
    end

endmodule

// File: rtl/scl_div_calc_chk.sv
module scl_div_calc_chk
    import scl_div_pkg::*;
#(
    parameter int FIELD_W = 4,
    parameter int DIV_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DIV_W-1:0]  divisor,
    input logic [WORD_W-1:0] timing_word,
    input logic              clamped,
    input logic              done
);

    localparam int PHASE_MAX = 2 ** (FIELD_W + 1);
    localparam int LAT_MAX   = 2 * (EXP_LAST + 1) + 2;
    localparam logic [WORD_W-1:0] FMASK    = WORD_W'((1 << FIELD_W) - 1);
    localparam logic [WORD_W-1:0] USED_MSK = (FMASK << HI_LSB) | (FMASK << LO_LSB)
                                           | WORD_W'((1 << EXP_W) - 1);

    logic             busy_q;
    logic [DIV_W-1:0] cap_q;
    logic [7:0]       wait_q;
    logic [FIELD_W-1:0] hi_f, lo_f;

    assign hi_f = timing_word[HI_LSB +: FIELD_W];
    assign lo_f = timing_word[LO_LSB +: FIELD_W];

    // Tracks an accepted request from the outside
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cap_q  <= '0;
            wait_q <= '0;
        end else if (!busy_q && start) begin
            busy_q <= 1'b1;
            cap_q  <= divisor;
            wait_q <= '0;
        end else if (busy_q) begin
            if (done) busy_q <= 1'b0;
            if (wait_q != 8'hFF) wait_q <= wait_q + 8'd1;
        end
    end

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_q);

    p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(timing_word) |-> done);

    p_clamp_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && clamped) |-> (timing_word[EXP_W-1:0] == EXP_W'(EXP_LAST))
                              && (hi_f == {FIELD_W{1'b1}}) && (lo_f == {FIELD_W{1'b1}}));

    p_exp_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cap_q <= DIV_W'(PHASE_MAX))) |-> (timing_word[EXP_W-1:0] == '0) && !clamped);

    p_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clamped) |-> ((lo_f == hi_f) || (lo_f == hi_f + FIELD_W'(1))));

    p_spare_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((timing_word & ~USED_MSK) == '0));

    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (wait_q <= 8'(LAT_MAX)));

endmodule

bind scl_div_calc scl_div_calc_chk #(
    .FIELD_W (FIELD_W),
    .DIV_W   (DIV_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .divisor     (divisor),
    .timing_word (timing_word),
    .clamped     (clamped),
    .done        (done)
);

// File: tb/scl_div_calc_tb.sv
`timescale 1ns/1ps
module scl_div_calc_tb_top;

    localparam int FW   = 4;
    localparam int MAXP = 2 ** (FW + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] divisor = '0;
    logic [31:0] timing_word;
    logic        clamped;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int pending = 0;

    typedef struct {
        logic [31:0] word;
        logic        clamp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    scl_div_calc #(.FIELD_W(FW), .DIV_W(32)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .divisor     (divisor),
        .timing_word (timing_word),
        .clamped     (clamped),
        .done        (done)
    );

    // Independent model: exponent from the bit length of (d-1)/MAXP
    function automatic logic [32:0] model(input logic [31:0] div);
        longint d, q, t, lo, hi;
        int e;
        logic [31:0] w;
        d = (div == 0) ? 64'd1 : longint'({32'b0, div});
        e = 0;
        if (d > MAXP) begin
            q = (d - 1) / MAXP;
            for (int i = 0; i < 40; i++) if (q[i]) e = i + 1;
        end
        if (e > 15) begin
            w = (32'((1 << FW) - 1) << 16) | (32'((1 << FW) - 1) << 12) | 32'd15;
            return {1'b1, w};
        end
        t = (d + (longint'(1) << e) - 1) >> e;
        if (t < 2) t = 2;
        lo = (t + 1) / 2;
        hi = t / 2;
        w = (32'(hi - 1) << 16) | (32'(lo - 1) << 12) | 32'(e);
        return {1'b0, w};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_exp(input logic [31:0] div, input logic [31:0] w, input logic c, input string tag);
        exp_t it;
        @(negedge clk);
        it.word = w; it.clamp = c; it.tag = tag;
        sb_q.push_back(it);
        pending++;
        divisor = div;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (pending == 0);
        @(negedge clk);
    endtask

    task automatic send(input logic [31:0] div, input string tag);
        logic [32:0] m;
        m = model(div);
        send_exp(div, m[31:0], m[32], tag);
    endtask

    // Monitor: pop and compare on every done
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8/R9 unexpected done", timing_word, 32'h0);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                check(timing_word == it.word, it.tag, timing_word, it.word);
                check(clamped == it.clamp, {it.tag, " clamp"}, 32'(clamped), 32'(it.clamp));
                pending--;
            end
        end
    end

    initial begin
        logic [32:0] m;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0 && clamped == 1'b0 && timing_word == '0, "R10 reset", timing_word, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && timing_word == '0, "R10 after reset", timing_word, 32'h0);

        send_exp(32'd0, 32'h0000_0000, 1'b0, "R7 zero divisor");
        send_exp(32'd1, 32'h0000_0000, 1'b0, "R4 divisor one raised to two ticks");
        send(32'd2, "R4 two ticks");
        send_exp(32'd7, 32'h0002_3000, 1'b0, "R5 odd split");
        send(32'd16, "R1 exponent zero mid");
        send_exp(32'd32, 32'h000F_F000, 1'b0, "R1 exponent zero at max");
        send_exp(32'd33, 32'h0007_8001, 1'b0, "R6 packing at first step");
        send(32'd64, "R2 exact power boundary");
        send(32'd65, "R2 just past boundary");
        send(32'd1000, "R4 round up");
        send(32'd12345, "R2 mid range");
        send_exp(32'h0010_0000, 32'h000F_F00F, 1'b0, "R3 largest unclamped");
        send_exp(32'h0010_0001, 32'h000F_F00F, 1'b1, "R3 first clamped");
        send(32'hFFFF_FFFF, "R3 all ones divisor");

        // R8: result holds after done
        send(32'd500, "R8 result");
        repeat (20) @(negedge clk);
        m = model(32'd500);
        check(done == 1'b0 && timing_word == m[31:0], "R8 hold", timing_word, m[31:0]);

        // R9: second start while busy is dropped
        m = model(32'd1000);
        begin
            exp_t it;
            @(negedge clk);
            it.word = m[31:0]; it.clamp = m[32]; it.tag = "R9 first start wins";
            sb_q.push_back(it);
            pending++;
            divisor = 32'd1000;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            divisor = 32'd5;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait (pending == 0);
        end
        repeat (40) @(negedge clk);
        check(timing_word == m[31:0], "R9 no second result", timing_word, m[31:0]);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule